// File: doc/BRIEF.md
# Split-Transaction Memory Switch Port

This block lets several bus masters, such as processor cores and DMA engines, share one memory target. The switch passes commands through with split transactions. A master issues a command and goes on with its work. It never waits for the memory to finish. Read commands carry only an address and take a single beat. A write command takes one header beat that carries the address, followed by one beat for each data word. The last beat of a write is marked with an end flag. The switch arbitrates round robin among masters that are requesting. Once a write burst starts, the grant stays with that burst until its end beat has been accepted.

A write is complete for the master as soon as the switch accepts its final beat. Nothing comes back from the memory for it. For reads, the switch records the ID of each issuing master in a small FIFO, in issue order. Read data then comes back on a separate response channel and is steered to the master at the head of that FIFO. Every channel uses valid/ready flow control. A chip instantiates one such switch per memory target, so traffic to different targets proceeds in parallel.

Top module: `xbarPort`

## Requirements
- R1: A read beat from the granted master is presented on the target request channel in the same cycle, with `tReqWrite`=0, the master's address, and `tReqSrc` equal to the master's index (0 to NUM_MASTERS-1).
- R2: Once a write beat with `mReqEop`=0 is accepted, no other master is granted until a write beat with `mReqEop`=1 from the same master has been accepted. A write command is a header beat carrying the address, then data beats, with the end flag on the last data beat.
- R3: `mReqReady[i]` is high only in a cycle where master i is granted and `tReqReady` is high, and at most one `mReqReady` bit is high. A beat transfers only when valid and ready are both high.
- R4: Outside a burst, the grant goes to the first eligible master, searching upward (wrapping around) from the index one above the master whose beat was accepted last. After reset the search starts at master 0.
- R5: A read response is routed only to the master whose read is oldest among those not yet answered. `mRspValid` has at most one bit set, and `mRspData` carries `tRspData`.
- R6: While READ_DEPTH reads are outstanding, no read beat is accepted, and write beats are still accepted.
- R7: While no read is outstanding, `tRspReady` stays low and no `mRspValid` bit is raised, even if `tRspValid` is high.
- R8: After reset, `tReqValid`, `mReqReady`, `tRspReady` and `mRspValid` are all low, and no read is outstanding.
- R9: `tRspReady` is high exactly when a read is outstanding and the master at the head of the order has its `mRspReady` bit high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| mReqValid | input | NUM_MASTERS | Per-master request valid |
| mReqWrite | input | NUM_MASTERS | Per-master beat is part of a write (1) or a read (0) |
| mReqEop | input | NUM_MASTERS | Per-master last beat of a write command |
| mReqAddr | input | NUM_MASTERS*ADDR_W | Per-master address, master i at bits [i*ADDR_W +: ADDR_W] |
| mReqData | input | NUM_MASTERS*DATA_W | Per-master write data, master i at bits [i*DATA_W +: DATA_W] |
| mReqReady | output | NUM_MASTERS | Per-master local accept |
| tReqValid | output | 1 | Request to target valid |
| tReqWrite | output | 1 | Forwarded write flag |
| tReqEop | output | 1 | Forwarded end flag |
| tReqAddr | output | ADDR_W | Forwarded address |
| tReqData | output | DATA_W | Forwarded write data |
| tReqSrc | output | $clog2(NUM_MASTERS) | Index of granted master |
| tReqReady | input | 1 | Target accepts request beat |
| tRspValid | input | 1 | Read data from target valid |
| tRspData | input | DATA_W | Read data from target |
| tRspReady | output | 1 | Switch accepts read data |
| mRspValid | output | NUM_MASTERS | Per-master read data valid |
| mRspData | output | DATA_W | Read data to masters |
| mRspReady | input | NUM_MASTERS | Per-master read data ready |

## Verification
A corrupt read-order FIFO entry shows up at the ports on the next response that pops it: the wrong `mRspValid` bit rises in that same cycle. A wrong occupancy count shows up in one of two ways. Reads are refused early at the request side, or responses are accepted when none is outstanding. A lost burst lock lets another master's `tReqSrc` appear in the middle of a burst, in the cycle right after an accepted non-final write beat. A wrong round-robin pointer changes `tReqSrc` on the very next contested cycle.

// File: rtl/xbarPkg.sv
package xbarPkg;
  // Strobes the control block sends to the datapath each cycle.
  typedef struct packed {
    logic push;   // record the granted master as a read issuer
    logic pop;    // retire the oldest read issuer
  } ctlStrobes_t;
endpackage

// File: rtl/xbarCtl.sv
module xbarCtl
  import xbarPkg::*;
#(
  parameter int NUM_MASTERS = 4,
  parameter int READ_DEPTH  = 4,
  localparam int IDW  = (NUM_MASTERS > 1) ? $clog2(NUM_MASTERS) : 1,
  localparam int CNTW = $clog2(READ_DEPTH + 1)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [NUM_MASTERS-1:0] reqValid,
  input  logic [NUM_MASTERS-1:0] reqWrite,
  input  logic [NUM_MASTERS-1:0] reqEop,
  input  logic                   tReqReady,
  input  logic                   tRspValid,
  input  logic                   rspReadyHead,
  output logic [IDW-1:0]         grantIdx,
  output logic                   anyGrant,
  output logic [NUM_MASTERS-1:0] reqReady,
  output logic                   tRspReady,
  output logic                   nonEmpty,
  output ctlStrobes_t            strobes
);
  logic [IDW-1:0]         rrPtr, lockOwner;
  logic                   locked;
  logic [CNTW-1:0]        count;
  logic [NUM_MASTERS-1:0] eligible;
  logic                   rdFull, accept, pickWrite, pickEop;

  assign rdFull   = (count == CNTW'(READ_DEPTH));
  assign nonEmpty = (count != '0);

  for (genvar i = 0; i < NUM_MASTERS; i++) begin : g_elig
    assign eligible[i] = reqValid[i] && (reqWrite[i] || !rdFull) &&
                         (!locked || lockOwner == IDW'(i));
    assign reqReady[i] = accept && (grantIdx == IDW'(i));
  end

  always_comb begin
    int idx;
    anyGrant = 1'b0;
    grantIdx = '0;
    for (int k = 0; k < NUM_MASTERS; k++) begin
      idx = int'(rrPtr) + k;
      if (idx >= NUM_MASTERS) idx = idx - NUM_MASTERS;
      if (!anyGrant && eligible[idx]) begin
        anyGrant = 1'b1;
        grantIdx = IDW'(idx);
      end
    end
  end

  assign accept       = anyGrant && tReqReady;
  assign pickWrite    = reqWrite[grantIdx];
  assign pickEop      = reqEop[grantIdx];
  assign tRspReady    = nonEmpty && rspReadyHead;
  assign strobes.push = accept && !pickWrite;
  assign strobes.pop  = tRspValid && tRspReady;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rrPtr     <= '0;
      lockOwner <= '0;
      locked    <= 1'b0;
      count     <= '0;
    end else begin
      if (accept) begin
        rrPtr <= (grantIdx == IDW'(NUM_MASTERS - 1)) ? '0 : grantIdx + 1'b1;
        if (pickWrite) begin
          locked    <= !pickEop;
          lockOwner <= grantIdx;
        end
      end
      count <= count + CNTW'(strobes.push) - CNTW'(strobes.pop);
    end
  end

  AST_NO_OVERFLOW:   assert property (@(posedge clk) disable iff (!rstN) count <= CNTW'(READ_DEPTH)); // R6
  AST_FULL_NO_READ:  assert property (@(posedge clk) disable iff (!rstN) rdFull |-> !strobes.push); // R6
  AST_NO_UNDERFLOW:  assert property (@(posedge clk) disable iff (!rstN) strobes.pop |-> nonEmpty); // R7
  AST_READY_ONEHOT:  assert property (@(posedge clk) disable iff (!rstN) $onehot0(reqReady)); // R3
  AST_BURST_LOCK:    assert property (@(posedge clk) disable iff (!rstN)
                       (accept && pickWrite && !pickEop) |=> (!anyGrant || grantIdx == $past(grantIdx))); // R2
endmodule

// File: rtl/xbarData.sv
module xbarData
  import xbarPkg::*;
#(
  parameter int NUM_MASTERS = 4,
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 32,
  parameter int READ_DEPTH  = 4,
  localparam int IDW  = (NUM_MASTERS > 1) ? $clog2(NUM_MASTERS) : 1,
  localparam int PTRW = (READ_DEPTH > 1) ? $clog2(READ_DEPTH) : 1
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [NUM_MASTERS-1:0]        mReqValid,
  input  logic [NUM_MASTERS-1:0]        mReqWrite,
  input  logic [NUM_MASTERS-1:0]        mReqEop,
  input  logic [NUM_MASTERS*ADDR_W-1:0] mReqAddr,
  input  logic [NUM_MASTERS*DATA_W-1:0] mReqData,
  input  logic [IDW-1:0]                grantIdx,
  input  logic                          anyGrant,
  input  logic                          nonEmpty,
  input  ctlStrobes_t                   strobes,
  input  logic                          tRspValid,
  input  logic [DATA_W-1:0]             tRspData,
  input  logic [NUM_MASTERS-1:0]        mRspReady,
  output logic                          tReqWrite,
  output logic                          tReqEop,
  output logic [ADDR_W-1:0]             tReqAddr,
  output logic [DATA_W-1:0]             tReqData,
  output logic [IDW-1:0]                tReqSrc,
  output logic                          rspReadyHead,
  output logic [NUM_MASTERS-1:0]        mRspValid,
  output logic [DATA_W-1:0]             mRspData
);
  logic [IDW-1:0]  idMem [READ_DEPTH];
  logic [PTRW-1:0] wrPtr, rdPtr;
  logic [IDW-1:0]  headId;

  assign tReqWrite = mReqWrite[grantIdx];
  assign tReqEop   = mReqEop[grantIdx];
  assign tReqAddr  = mReqAddr[grantIdx*ADDR_W +: ADDR_W];
  assign tReqData  = mReqData[grantIdx*DATA_W +: DATA_W];
  assign tReqSrc   = grantIdx;

  assign headId       = idMem[rdPtr];
  assign rspReadyHead = mRspReady[headId];
  assign mRspData     = tRspData;

  for (genvar i = 0; i < NUM_MASTERS; i++) begin : g_rsp
    assign mRspValid[i] = tRspValid && nonEmpty && (headId == IDW'(i));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (strobes.push) begin
        idMem[wrPtr] <= grantIdx;
        wrPtr <= (wrPtr == PTRW'(READ_DEPTH - 1)) ? '0 : wrPtr + 1'b1;
      end
      if (strobes.pop)
        rdPtr <= (rdPtr == PTRW'(READ_DEPTH - 1)) ? '0 : rdPtr + 1'b1;
    end
  end

  AST_RSP_ONEHOT:     assert property (@(posedge clk) disable iff (!rstN) $onehot0(mRspValid)); // R5
  AST_SRC_REQUESTING: assert property (@(posedge clk) disable iff (!rstN) anyGrant |-> mReqValid[grantIdx]); // R3
  AST_RSP_NEEDS_READ: assert property (@(posedge clk) disable iff (!rstN) (|mRspValid) |-> nonEmpty); // R7
endmodule

// File: rtl/xbarPort.sv
module xbarPort
  import xbarPkg::*;
#(
  parameter int NUM_MASTERS = 4,
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 32,
  parameter int READ_DEPTH  = 4,
  localparam int IDW = (NUM_MASTERS > 1) ? $clog2(NUM_MASTERS) : 1
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [NUM_MASTERS-1:0]        mReqValid,
  input  logic [NUM_MASTERS-1:0]        mReqWrite,
  input  logic [NUM_MASTERS-1:0]        mReqEop,
  input  logic [NUM_MASTERS*ADDR_W-1:0] mReqAddr,
  input  logic [NUM_MASTERS*DATA_W-1:0] mReqData,
  output logic [NUM_MASTERS-1:0]        mReqReady,
  output logic                          tReqValid,
  output logic                          tReqWrite,
  output logic                          tReqEop,
  output logic [ADDR_W-1:0]             tReqAddr,
  output logic [DATA_W-1:0]             tReqData,
  output logic [IDW-1:0]                tReqSrc,
  input  logic                          tReqReady,
  input  logic                          tRspValid,
  input  logic [DATA_W-1:0]             tRspData,
  output logic                          tRspReady,
  output logic [NUM_MASTERS-1:0]        mRspValid,
  output logic [DATA_W-1:0]             mRspData,
  input  logic [NUM_MASTERS-1:0]        mRspReady
);
  logic [IDW-1:0] grantIdx;
  logic           anyGrant, nonEmpty, rspReadyHead;
  ctlStrobes_t    strobes;

  assign tReqValid = anyGrant;

  xbarCtl #(.NUM_MASTERS(NUM_MASTERS), .READ_DEPTH(READ_DEPTH)) u_ctl (
    .clk(clk), .rstN(rstN), .reqValid(mReqValid), .reqWrite(mReqWrite),
    .reqEop(mReqEop), .tReqReady(tReqReady), .tRspValid(tRspValid),
    .rspReadyHead(rspReadyHead), .grantIdx(grantIdx), .anyGrant(anyGrant),
    .reqReady(mReqReady), .tRspReady(tRspReady), .nonEmpty(nonEmpty),
    .strobes(strobes)
  );

  xbarData #(.NUM_MASTERS(NUM_MASTERS), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
             .READ_DEPTH(READ_DEPTH)) u_data (
    .clk(clk), .rstN(rstN), .mReqValid(mReqValid), .mReqWrite(mReqWrite),
    .mReqEop(mReqEop), .mReqAddr(mReqAddr), .mReqData(mReqData),
    .grantIdx(grantIdx), .anyGrant(anyGrant), .nonEmpty(nonEmpty),
    .strobes(strobes), .tRspValid(tRspValid), .tRspData(tRspData),
    .mRspReady(mRspReady), .tReqWrite(tReqWrite), .tReqEop(tReqEop),
    .tReqAddr(tReqAddr), .tReqData(tReqData), .tReqSrc(tReqSrc),
    .rspReadyHead(rspReadyHead), .mRspValid(mRspValid), .mRspData(mRspData)
  );
endmodule

// File: tb/xbarPort_bench.sv
`timescale 1ns/1ps
module xbarPort_bench;
  localparam int N = 4, AW = 16, DW = 32, DEPTH = 4, CYCLES = 6000;

  logic clk = 1'b0, rstN = 1'b0;
  logic [N-1:0] mv = '0, mw = '0, me = '0, mReqReady, mRspValid, mRspReady = '0;
  logic [N*AW-1:0] ma = '0;
  logic [N*DW-1:0] md = '0;
  logic tReqValid, tReqWrite, tReqEop, tReqReady = 1'b0, tRspValid = 1'b0, tRspReady;
  logic [AW-1:0] tReqAddr;
  logic [DW-1:0] tReqData, tRspData = '0, mRspData;
  logic [1:0] tReqSrc;

  int nChk = 0, nBad = 0;
  bit done = 0;

  xbarPort #(.NUM_MASTERS(N), .ADDR_W(AW), .DATA_W(DW), .READ_DEPTH(DEPTH)) u_xbarPort (
    .clk(clk), .rstN(rstN), .mReqValid(mv), .mReqWrite(mw), .mReqEop(me),
    .mReqAddr(ma), .mReqData(md), .mReqReady(mReqReady), .tReqValid(tReqValid),
    .tReqWrite(tReqWrite), .tReqEop(tReqEop), .tReqAddr(tReqAddr), .tReqData(tReqData),
    .tReqSrc(tReqSrc), .tReqReady(tReqReady), .tRspValid(tRspValid), .tRspData(tRspData),
    .tRspReady(tRspReady), .mRspValid(mRspValid), .mRspData(mRspData), .mRspReady(mRspReady));

  always #10 clk = ~clk;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // Reference model state
  int ptr = 0, owner = 0, left [N];
  bit lockOn = 0;
  int idq[$];
  logic [DW-1:0] tq[$];
  int fullBlockSeen = 0, writeWhileFull = 0, burstBlockSeen = 0;

  function automatic int pickMaster(input logic [N-1:0] elig, input int p);
    for (int k = 0; k < N; k++) if (elig[(p + k) % N]) return (p + k) % N;
    return -1;
  endfunction

  initial begin : watchdog
    repeat (CYCLES + 1000) @(posedge clk);
    if (!done) begin
      nBad++; nChk++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end

  initial begin : stim
    logic [N-1:0] acc, elig, expReady, expRspV;
    int g, rspProb, reqProb;
    bit expTRdy, accept;
    void'($urandom(32'h5EED1234));
    for (int i = 0; i < N; i++) left[i] = 0;
    acc = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R8: reset values
    chk("R8 tReqValid", tReqValid, 0);
    chk("R8 mReqReady", mReqReady, 0);
    chk("R8 tRspReady", tRspReady, 0);
    chk("R8 mRspValid", mRspValid, 0);
    rstN = 1'b1;
    for (int cyc = 0; cyc < CYCLES; cyc++) begin
      @(negedge clk);
      rspProb = (cyc < 2000) ? 50 : (cyc < 3500) ? 0 : 90;
      reqProb = (cyc < 2000) ? 40 : 70;
      for (int i = 0; i < N; i++) begin
        if (acc[i]) begin
          if (mw[i] && !me[i]) begin
            md[i*DW +: DW] = $urandom;
            me[i] = (left[i] == 1);
            left[i]--;
          end else mv[i] = 1'b0;
        end
        if (!mv[i] && ($urandom % 100) < reqProb) begin
          mv[i] = 1'b1;
          mw[i] = $urandom % 2;
          ma[i*AW +: AW] = AW'($urandom);
          md[i*DW +: DW] = $urandom;
          me[i] = !mw[i];
          left[i] = mw[i] ? 1 + ($urandom % 3) : 0;
        end
      end
      tReqReady = ($urandom % 100) < 70;
      mRspReady = N'($urandom);
      if (cyc < 3) begin
        tRspValid = (tq.size() == 0);  // spurious response, nothing outstanding
        tRspData  = 32'hDEAD0000;
      end else begin
        tRspValid = (tq.size() > 0) && (($urandom % 100) < rspProb);
        tRspData  = (tq.size() > 0) ? tq[0] : '0;
      end
      #1;
      for (int i = 0; i < N; i++)
        elig[i] = mv[i] && (mw[i] || idq.size() < DEPTH) && (!lockOn || owner == i);
      g = pickMaster(elig, ptr);
      accept = (g >= 0) && tReqReady;
      expReady = accept ? N'(1 << g) : '0;
      chk("R3 tReqValid", tReqValid, g >= 0);
      chk("R3 mReqReady", mReqReady, expReady);
      if (g >= 0) begin
        chk("R4 tReqSrc", tReqSrc, g);
        chk("R1 tReqWrite", tReqWrite, mw[g]);
        chk("R1 tReqAddr", tReqAddr, ma[g*AW +: AW]);
        if (mw[g]) begin
          chk("R2 tReqEop", tReqEop, me[g]);
          chk("R2 tReqData", tReqData, md[g*DW +: DW]);
        end
      end
      if (lockOn && (mv & ~N'(1 << owner)) != 0) begin
        burstBlockSeen++;
        chk("R2 no foreign grant", (g < 0) || (g == owner), 1);
      end
      for (int i = 0; i < N; i++) begin
        if (idq.size() == DEPTH && mv[i] && !mw[i]) begin
          fullBlockSeen++;
          chk("R6 read refused when full", mReqReady[i], 0);
        end
        if (idq.size() == DEPTH && accept && g == i && mw[i]) writeWhileFull++;
      end
      expTRdy = (idq.size() > 0) && mRspReady[idq.size() > 0 ? idq[0] : 0];
      expRspV = (tRspValid && idq.size() > 0) ? N'(1 << idq[0]) : '0;
      if (idq.size() == 0) begin
        chk("R7 tRspReady empty", tRspReady, 0);
        chk("R7 mRspValid empty", mRspValid, 0);
      end else begin
        chk("R9 tRspReady", tRspReady, expTRdy);
        chk("R5 mRspValid", mRspValid, expRspV);
        if (tRspValid) chk("R5 mRspData", mRspData, tRspData);
      end
      acc = mv & mReqReady;
      @(posedge clk);
      if (accept) begin
        if (mw[g]) begin
          lockOn = !me[g];
          owner = g;
        end else begin
          idq.push_back(g);
          tq.push_back({ma[g*AW +: AW], ~ma[g*AW +: AW]});
        end
        ptr = (g + 1) % N;
      end
      if (tRspValid && expTRdy) begin
        void'(idq.pop_front());
        void'(tq.pop_front());
      end
    end
    chk("R6 full case reached", fullBlockSeen > 0, 1);
    chk("R6 write while full", writeWhileFull > 0, 1);
    chk("R2 contested burst seen", burstBlockSeen > 0, 1);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule